// File: doc/BRIEF.md
# Floating-Point Load Data Formatter

This block sits between the load data return path and the floating-point register file. It takes the raw bits read from memory and turns them into the 64-bit value that the register receives. A two-bit kind select picks the treatment. A 32-bit single-precision operand is widened to double precision. A 64-bit doubleword is forwarded unchanged. A 32-bit integer word is sign-extended or zero-extended into the low half of the register.

The widening path handles every class of single-precision value. Signed zeros stay zeros. Normal numbers are rebiased. Denormals are normalized with a leading-zero count. Infinities and NaNs keep their payload and quiet bit.

The result leaves through one register stage, paired with a valid flag. Address generation, byte reordering and the memory protocol belong to neighbouring blocks.

Top module: `fp_load_fmt`

## Requirements
- R1: While `rst` is high, and at the first edge after it, `out_vld` is 0 and `out_data` is all zeros.
- R2: Kind 0 (single widen) reads the word `in_data[31:0]` as an IEEE single. For a normal value, the output keeps the sign, takes exponent + 896 as an 11-bit exponent in `out_data[62:52]`, and places the 23 fraction bits in `out_data[51:29]`, with `out_data[28:0]` zero.
- R3: Kind 0 with a single exponent and fraction both zero gives a double zero of the same sign: bit 63 equals input bit 31, and all other bits are 0.
- R4: Kind 0 with a zero exponent and a nonzero fraction is normalized. If z is the number of leading zeros of the 23-bit fraction, the output exponent is 896 - z. The output fraction is the input fraction shifted left by z+1, with the top 23 bits kept and 29 zero bits appended.
- R5: Kind 0 with a single exponent of 255 gives a double exponent of 2047 (`out_data[62:52]` all ones) with the fraction copied into `out_data[51:29]`. Infinities, NaN payloads and the quiet bit are therefore kept.
- R6: Kind 1 (double pass) places `in_data[63:0]` in `out_data` unchanged.
- R7: Kind 2 (word sign-extend) places `in_data[31:0]` in `out_data[31:0]` and fills `out_data[63:32]` with copies of `in_data[31]`.
- R8: Kind 3 (word zero-extend) places `in_data[31:0]` in `out_data[31:0]` and clears `out_data[63:32]`. For kinds 0, 2 and 3, `in_data[63:32]` has no effect on the result.
- R9: A result captured at a clock edge where `in_vld` is high appears on `out_data`, with `out_vld` high, right after that edge. `out_vld` is low after an edge where `in_vld` was low. Back-to-back inputs give back-to-back results.
- R10: At an edge where `in_vld` is low, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input data valid |
| in_kind | input | 2 | Load kind: 0 single widen, 1 double pass, 2 word sign-extend, 3 word zero-extend |
| in_data | input | 64 | Raw memory data; word kinds use bits 31:0 |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_data | output | 64 | Formatted register value |

## Verification
The widening path is tried with one value from each class:
- normals at both ends of the exponent range and one in between, which expose a wrong rebias constant or a misplaced fraction;
- denormals with leading-zero counts of 0, 1 and 22, which separate a wrong exponent adjustment from a wrong shift amount;
- positive and negative zero, infinity, and quiet and signalling NaNs, which check sign handling and payload copying.

The word kinds get words with bit 31 set and clear, and the upper input half is filled with junk. This tells sign fill from zero fill and catches any leak of the unused half. Back-to-back inputs, a valid-low gap and a reset in mid-stream show the one-cycle latency and the hold behaviour.

// File: rtl/fp_ld_pkg.sv
package fp_ld_pkg;
   typedef enum logic [1:0] {
      KIND_SGL_WIDEN = 2'd0,
      KIND_DBL_PASS  = 2'd1,
      KIND_WORD_SEXT = 2'd2,
      KIND_WORD_ZEXT = 2'd3
   } ld_kind_e;
endpackage

// File: rtl/fp_ld_lzc.sv
module fp_ld_lzc #(
   parameter int W  = 23,
   localparam int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] cnt
);
   generate
      if (W < 2) begin : g_bad_w
         $error("fp_ld_lzc: W must be at least 2");
      end
   endgenerate

   always_comb begin
      logic found;
      found = 1'b0;
      cnt   = CW'(W);
      for (int i = W - 1; i >= 0; i--) begin
         if (!found && vec[i]) begin
            cnt   = CW'(W - 1 - i);
            found = 1'b1;
         end
      end
   end
endmodule

// File: rtl/fp_ld_widen.sv
module fp_ld_widen #(
   parameter int SE = 8,
   parameter int SM = 23,
   parameter int DE = 11,
   parameter int DM = 52,
   localparam int SW = 1 + SE + SM,
   localparam int DW = 1 + DE + DM
) (
   input  logic [SW-1:0] sgl,
   output logic [DW-1:0] dbl
);
   localparam int BIAS_S = (1 << (SE - 1)) - 1;
   localparam int BIAS_D = (1 << (DE - 1)) - 1;
   localparam int REBIAS = BIAS_D - BIAS_S;
   localparam int PADW   = DM - SM;
   localparam int LZW    = $clog2(SM + 1);

   generate
      if (DE <= SE || DM <= SM) begin : g_bad_fmt
         $error("fp_ld_widen: double format must be wider than single");
      end
   endgenerate

   logic          sgn;
   logic [SE-1:0] exp_s;
   logic [SM-1:0] frac_s;
   logic [LZW-1:0] lz;
   logic [SM-1:0] frac_norm;

   assign sgn    = sgl[SW-1];
   assign exp_s  = sgl[SE+SM-1:SM];
   assign frac_s = sgl[SM-1:0];

   fp_ld_lzc #(.W(SM)) u_lzc (
      .vec (frac_s),
      .cnt (lz)
   );

   // drop the leading one of a denormal fraction
   assign frac_norm = SM'({frac_s, 1'b0} << lz);

   always_comb begin
      if (exp_s == '0 && frac_s == '0) begin
         dbl = {sgn, {(DW-1){1'b0}}};
      end else if (exp_s == '1) begin
         dbl = {sgn, {DE{1'b1}}, frac_s, {PADW{1'b0}}};
      end else if (exp_s == '0) begin
         dbl = {sgn, DE'(REBIAS) - DE'(lz), frac_norm, {PADW{1'b0}}};
      end else begin
         dbl = {sgn, DE'(exp_s) + DE'(REBIAS), frac_s, {PADW{1'b0}}};
      end
   end
endmodule

// File: rtl/fp_ld_extend.sv
module fp_ld_extend #(
   parameter int WW = 32,
   parameter int RW = 64
) (
   input  logic [WW-1:0] word,
   input  logic          fill_sign,
   output logic [RW-1:0] ext
);
   generate
      if (RW <= WW) begin : g_bad_w
         $error("fp_ld_extend: result must be wider than word");
      end
   endgenerate

   logic fill_bit;
   assign fill_bit = fill_sign & word[WW-1];
   assign ext      = {{(RW-WW){fill_bit}}, word};
endmodule

// File: rtl/fp_load_fmt.sv
module fp_load_fmt #(
   parameter int SGL_EXP_W = 8,
   parameter int SGL_MAN_W = 23,
   parameter int DBL_EXP_W = 11,
   parameter int DBL_MAN_W = 52,
   localparam int WORD_W = 1 + SGL_EXP_W + SGL_MAN_W,
   localparam int DATA_W = 1 + DBL_EXP_W + DBL_MAN_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_vld,
   input  logic [1:0]        in_kind,
   input  logic [DATA_W-1:0] in_data,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   import fp_ld_pkg::*;

   generate
      if (DATA_W != 2 * WORD_W) begin : g_bad_ratio
         $error("fp_load_fmt: register must be twice the word width");
      end
   endgenerate

   ld_kind_e          kind;
   logic [DATA_W-1:0] widened;
   logic [DATA_W-1:0] extended;
   logic [DATA_W-1:0] nxt;

   assign kind = ld_kind_e'(in_kind);

   fp_ld_widen #(
      .SE (SGL_EXP_W), .SM (SGL_MAN_W),
      .DE (DBL_EXP_W), .DM (DBL_MAN_W)
   ) u_widen (
      .sgl (in_data[WORD_W-1:0]),
      .dbl (widened)
   );

   fp_ld_extend #(.WW(WORD_W), .RW(DATA_W)) u_ext (
      .word      (in_data[WORD_W-1:0]),
      .fill_sign (kind == KIND_WORD_SEXT),
      .ext       (extended)
   );

   always_comb begin
      unique case (kind)
         KIND_SGL_WIDEN: nxt = widened;
         KIND_DBL_PASS:  nxt = in_data;
         default:        nxt = extended;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_vld  <= 1'b0;
         out_data <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_data <= nxt;
      end
   end

   // R9: valid tracks input valid one cycle later
   p_vld_follow_r9: assert property (@(posedge clk) disable iff (rst)
      in_vld |=> out_vld);
   p_vld_idle_r9: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> !out_vld);
   // R10: data holds without a valid input
   p_hold_r10: assert property (@(posedge clk) disable iff (rst)
      !in_vld |=> $stable(out_data));
   // R6: doubleword passes unchanged
   p_pass_r6: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_kind == 2'd1) |=> out_data == $past(in_data));
   // R8: zero-extend clears upper half
   p_zext_r8: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_kind == 2'd3) |=> out_data[DATA_W-1:WORD_W] == '0);
   // R7: sign-extend fills upper half with word sign
   p_sext_r7: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_kind == 2'd2) |=>
         out_data[DATA_W-1:WORD_W] == {WORD_W{$past(in_data[WORD_W-1])}});
   // R5: all-ones single exponent gives all-ones double exponent
   p_special_r5: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_kind == 2'd0 && in_data[WORD_W-2:SGL_MAN_W] == '1) |=>
         out_data[DATA_W-2:DBL_MAN_W] == '1);
   // R2: widened value keeps its sign
   p_sign_r2: assert property (@(posedge clk) disable iff (rst)
      (in_vld && in_kind == 2'd0) |=>
         out_data[DATA_W-1] == $past(in_data[WORD_W-1]));
endmodule

// File: tb/fp_load_fmt_tb.sv
module fp_load_fmt_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 17;

   // {kind, data in, expected}
   localparam logic [129:0] VEC [0:NV-1] = '{
      {2'd0, 64'h00000000_3F800000, 64'h3FF00000_00000000},
      {2'd0, 64'h00000000_C0490FDB, 64'hC00921FB_60000000},
      {2'd0, 64'h00000000_00800000, 64'h38100000_00000000},
      {2'd0, 64'h00000000_7F7FFFFF, 64'h47EFFFFF_E0000000},
      {2'd0, 64'h00000000_00000000, 64'h00000000_00000000},
      {2'd0, 64'h00000000_80000000, 64'h80000000_00000000},
      {2'd0, 64'h00000000_00000001, 64'h36A00000_00000000},
      {2'd0, 64'h00000000_007FFFFF, 64'h380FFFFF_C0000000},
      {2'd0, 64'h00000000_80200000, 64'hB7F00000_00000000},
      {2'd0, 64'h00000000_7F800000, 64'h7FF00000_00000000},
      {2'd0, 64'h00000000_7FC00001, 64'h7FF80000_20000000},
      {2'd0, 64'h00000000_FF800001, 64'hFFF00000_20000000},
      {2'd1, 64'h01234567_89ABCDEF, 64'h01234567_89ABCDEF},
      {2'd2, 64'hDEADBEEF_80000001, 64'hFFFFFFFF_80000001},
      {2'd2, 64'hFFFFFFFF_7FFFFFFF, 64'h00000000_7FFFFFFF},
      {2'd3, 64'hCAFEBABE_80000001, 64'h00000000_80000001},
      {2'd0, 64'hFFFFFFFF_3F800000, 64'h3FF00000_00000000}
   };

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_vld = 1'b0;
   logic [1:0]  in_kind = 2'd0;
   logic [63:0] in_data = '0;
   logic        out_vld;
   logic [63:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fp_load_fmt u_dut (
      .clk      (clk),
      .rst      (rst),
      .in_vld   (in_vld),
      .in_kind  (in_kind),
      .in_data  (in_data),
      .out_vld  (out_vld),
      .out_data (out_data)
   );

   function automatic string tag_of(int i);
      case (i)
         0, 1, 2, 3: return "R2";
         4, 5:       return "R3";
         6, 7, 8:    return "R4";
         9, 10, 11:  return "R5";
         12:         return "R6";
         13, 14:     return "R7";
         default:    return "R8";
      endcase
   endfunction

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] last;
      repeat (3) @(negedge clk);
      check("R1", {63'd0, out_vld}, 64'd0);
      check("R1", out_data, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      check("R1", {63'd0, out_vld}, 64'd0);
      check("R1", out_data, 64'd0);

      // table walk, back-to-back inputs (R9)
      for (int i = 0; i < NV; i++) begin
         in_vld  = 1'b1;
         in_kind = VEC[i][129:128];
         in_data = VEC[i][127:64];
         @(negedge clk);
         check("R9", {63'd0, out_vld}, 64'd1);
         check(tag_of(i), out_data, VEC[i][63:0]);
      end
      last = VEC[NV-1][63:0];

      // gap: junk data with valid low must not change the result (R10)
      in_vld  = 1'b0;
      in_kind = 2'd1;
      in_data = 64'h5555AAAA_5555AAAA;
      @(negedge clk);
      check("R9", {63'd0, out_vld}, 64'd0);
      check("R10", out_data, last);
      @(negedge clk);
      check("R10", out_data, last);

      // upper half ignored by zero-extend (R8)
      in_vld  = 1'b1;
      in_kind = 2'd3;
      in_data = 64'hFFFFFFFF_00000000;
      @(negedge clk);
      check("R8", out_data, 64'd0);

      // single valid pulse then idle (R9)
      in_vld  = 1'b1;
      in_kind = 2'd2;
      in_data = 64'h00000000_FFFFFFFE;
      @(negedge clk);
      in_vld = 1'b0;
      check("R7", out_data, 64'hFFFFFFFF_FFFFFFFE);
      @(negedge clk);
      check("R9", {63'd0, out_vld}, 64'd0);

      // mid-stream reset (R1)
      in_vld  = 1'b1;
      in_kind = 2'd1;
      in_data = 64'h12345678_9ABCDEF0;
      rst     = 1'b1;
      @(negedge clk);
      check("R1", {63'd0, out_vld}, 64'd0);
      check("R1", out_data, 64'd0);
      rst    = 1'b0;
      @(negedge clk);
      check("R6", out_data, 64'h12345678_9ABCDEF0);
      in_vld = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule